// File: doc/BRIEF.md
# Multi-Width Shift and Rotate Unit

This block shifts or rotates an operand that sits in the low 8, 16 or 32 bits of a 32-bit word. A two-bit operation code picks right shift, left shift, right rotate or left rotate. A mode bit changes each operation to a second form. Right shift becomes arithmetic. Left shift fills vacated bits with a copy of bit 0. The rotates change from a rotate through carry to a rotate within the word. The count is an unsigned value of any size, so the caller can take it from a register without clamping it first.

The result, the carry flag and the N and Z flags are registered and appear one clock after the inputs. Bits of the word above the selected width pass through untouched. Decoding and register access are done outside the block.

Top module: `shf_unit`

## Requirements
- R1: The outputs are registered, so a result appears on the clock edge after its inputs are sampled. An active-low asynchronous reset clears res_o, c_o, n_o and z_o to 0.
- R2: wid_i selects the width W. Code 0 gives 8 bits, code 1 gives 16 bits, and codes 2 and 3 give 32 bits. Result bits at and above W equal the matching bits of opnd_i.
- R3: A count of 0 returns the operand unchanged, and c_o equals c_i.
- R4: op_i=0 with alt_i=0 is a logical right shift with zero fill. c_o is the last bit shifted out. A count equal to W gives 0 with c_o equal to operand bit W-1. A count above W gives 0 with c_o=0.
- R5: op_i=0 with alt_i=1 is an arithmetic right shift that fills with operand bit W-1. A count of W or more gives W copies of that bit. When the count is above W, c_o also equals that bit.
- R6: op_i=1 with alt_i=0 is a left shift with zero fill. c_o is operand bit W-n for counts from 1 to W. Counts above W give 0 with c_o=0.
- R7: op_i=1 with alt_i=1 is a left shift that fills every vacated bit with operand bit 0. Counts above W give all copies of bit 0, and c_o also equals bit 0.
- R8: op_i=2 (right) and op_i=3 (left) with alt_i=0 rotate the W+1-bit ring formed by c_i above the operand. The count is taken modulo W+1.
- R9: op_i=2 and op_i=3 with alt_i=1 rotate within W bits by the count modulo W. For a nonzero count, c_o is the bit that ended at the far end: result bit W-1 for a right rotate, result bit 0 for a left rotate.
- R10: n_o is result bit W-1. z_o is 1 exactly when result bits W-1 down to 0 are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 0 right shift, 1 left shift, 2 right rotate, 3 left rotate |
| alt_i | input | 1 | Selects the alternate form of the operation |
| wid_i | input | 2 | Width code: 0 gives 8 bits, 1 gives 16 bits, 2 and 3 give 32 bits |
| cnt_i | input | CNT_W | Unsigned shift or rotate count |
| opnd_i | input | DATA_W | Operand word |
| c_i | input | 1 | Incoming carry |
| res_o | output | DATA_W | Result word |
| c_o | output | 1 | Outgoing carry |
| n_o | output | 1 | Sign of the result at the selected width |
| z_o | output | 1 | Result is zero at the selected width |

## Verification
The block holds no state apart from its output register. A fault in the datapath or in the width select therefore shows up as a wrong res_o, c_o, n_o or z_o exactly one edge after the faulty input vector. No fault can stay hidden and surface later. Faults in the saturation and modulo logic show up only at counts at or beyond the width. For this reason the sweep runs the count past 2W+2 for every width, and also applies the largest count value.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [1:0] {
        OP_SHR = 2'd0,
        OP_SHL = 2'd1,
        OP_ROR = 2'd2,
        OP_ROL = 2'd3
    } shf_op_e;

    localparam int NUM_WIDTHS = 3;

    // Width code to width slot: 0 -> narrow, 1 -> half, others -> full.
    function automatic int unsigned wid_slot(input logic [1:0] code);
        unique case (code)
            2'd0:    return 0;
            2'd1:    return 1;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 8
) (
    input  logic [W-1:0]     data_i,
    input  shf_op_e          op_i,
    input  logic             alt_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             c_i,
    output logic [W-1:0]     data_o,
    output logic             c_o
);
    logic [31:0]    cnt_w;
    logic [31:0]    sat_amt;
    logic [31:0]    ring_amt;
    logic [31:0]    word_amt;
    logic           over;

    logic           rfill_bit;
    logic           lfill_bit;
    logic [2*W:0]   r_ext;
    logic [2*W:0]   l_ext;

    logic [W:0]     ring;
    logic [2*W+1:0] ring_dbl;
    logic [2*W+1:0] ring_r;
    logic [2*W+1:0] ring_l;
    logic [2*W-1:0] word_dbl;
    logic [2*W-1:0] word_r;
    logic [2*W-1:0] word_l;

    always_comb begin
        cnt_w    = 32'(cnt_i);
        over     = cnt_w > 32'(W);
        sat_amt  = over ? 32'(W) : cnt_w;
        ring_amt = cnt_w % 32'(W + 1);
        word_amt = cnt_w % 32'(W);

        rfill_bit = alt_i & data_i[W-1];
        lfill_bit = alt_i & data_i[0];
        r_ext     = {{W{rfill_bit}}, data_i, 1'b0} >> sat_amt;
        l_ext     = {1'b0, data_i, {W{lfill_bit}}} << sat_amt;

        ring     = {c_i, data_i};
        ring_dbl = {ring, ring};
        ring_r   = ring_dbl >> ring_amt;
        ring_l   = ring_dbl << ring_amt;
        word_dbl = {data_i, data_i};
        word_r   = word_dbl >> word_amt;
        word_l   = word_dbl << word_amt;
    end

    always_comb begin
        data_o = data_i;
        c_o    = c_i;
        if (cnt_w != 32'd0) begin
            unique case (op_i)
                OP_SHR: begin
                    data_o = r_ext[W:1];
                    c_o    = over ? rfill_bit : r_ext[0];
                end
                OP_SHL: begin
                    data_o = l_ext[2*W-1:W];
                    c_o    = over ? lfill_bit : l_ext[2*W];
                end
                OP_ROR: begin
                    if (alt_i) begin
                        data_o = word_r[W-1:0];
                        c_o    = word_r[W-1];
                    end else begin
                        data_o = ring_r[W-1:0];
                        c_o    = ring_r[W];
                    end
                end
                OP_ROL: begin
                    if (alt_i) begin
                        data_o = word_l[2*W-1:W];
                        c_o    = word_l[W];
                    end else begin
                        data_o = ring_l[2*W:W+1];
                        c_o    = ring_l[2*W+1];
                    end
                end
                default: begin
                    data_o = data_i;
                    c_o    = c_i;
                end
            endcase
        end
    end
endmodule

// File: rtl/shf_flags.sv
module shf_flags
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic [1:0]        wid_i,
    output logic              n_o,
    output logic              z_o
);
    localparam int W_NARROW = DATA_W / 4;
    localparam int W_HALF   = DATA_W / 2;

    always_comb begin
        unique case (wid_slot(wid_i))
            0: begin
                n_o = res_i[W_NARROW-1];
                z_o = ~|res_i[W_NARROW-1:0];
            end
            1: begin
                n_o = res_i[W_HALF-1];
                z_o = ~|res_i[W_HALF-1:0];
            end
            default: begin
                n_o = res_i[DATA_W-1];
                z_o = ~|res_i;
            end
        endcase
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic              alt_i,
    input  logic [1:0]        wid_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              n_o,
    output logic              z_o
);
    logic [DATA_W-1:0] cand_res [NUM_WIDTHS];
    logic              cand_c   [NUM_WIDTHS];
    logic [DATA_W-1:0] res_d;
    logic              c_d;
    logic              n_d;
    logic              z_d;
    shf_op_e           op_e;

    assign op_e = shf_op_e'(op_i);

    for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_width
        localparam int WS = DATA_W >> (NUM_WIDTHS - 1 - gi);
        logic [WS-1:0] slice_out;

        shf_core #(
            .W     (WS),
            .CNT_W (CNT_W)
        ) u_core (
            .data_i (opnd_i[WS-1:0]),
            .op_i   (op_e),
            .alt_i  (alt_i),
            .cnt_i  (cnt_i),
            .c_i    (c_i),
            .data_o (slice_out),
            .c_o    (cand_c[gi])
        );

        if (WS < DATA_W) begin : g_pass
            assign cand_res[gi] = {opnd_i[DATA_W-1:WS], slice_out};
        end else begin : g_full
            assign cand_res[gi] = slice_out;
        end
    end

    always_comb begin
        res_d = cand_res[wid_slot(wid_i)];
        c_d   = cand_c[wid_slot(wid_i)];
    end

    shf_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .res_i (res_d),
        .wid_i (wid_i),
        .n_o   (n_d),
        .z_o   (z_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o <= '0;
            c_o   <= 1'b0;
            n_o   <= 1'b0;
            z_o   <= 1'b0;
        end else begin
            res_o <= res_d;
            c_o   <= c_d;
            n_o   <= n_d;
            z_o   <= z_d;
        end
    end
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_i,
    input logic              alt_i,
    input logic [1:0]        wid_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic              c_i,
    input logic [DATA_W-1:0] res_o,
    input logic              c_o,
    input logic              n_o,
    input logic              z_o
);
    localparam int W_NARROW = DATA_W / 4;

    // R2: bits above the narrow width pass straight through
    a_r2_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wid_i) == 2'd0)
        |-> res_o[DATA_W-1:W_NARROW] == $past(opnd_i[DATA_W-1:W_NARROW]));

    // R3: a zero count changes neither word nor carry
    a_r3_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_i) == '0)
        |-> (res_o == $past(opnd_i) && c_o == $past(c_i)));

    // R4: a logical right shift by the width or more clears the narrow field
    a_r4_lsr_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'd0 && !$past(alt_i)
         && $past(wid_i) == 2'd0 && $past(cnt_i) >= CNT_W'(W_NARROW))
        |-> (res_o[W_NARROW-1:0] == '0 && z_o));

    // R9: an in-word right rotate leaves in C the bit now at the top
    a_r9_rot_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'd2 && $past(alt_i) && $past(cnt_i) != '0)
        |-> c_o == n_o);

    // R10: a zero result never shows a set sign
    a_r10_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
        z_o |-> !n_o);
endmodule

bind shf_unit shf_unit_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .alt_i  (alt_i),
    .wid_i  (wid_i),
    .cnt_i  (cnt_i),
    .opnd_i (opnd_i),
    .c_i    (c_i),
    .res_o  (res_o),
    .c_o    (c_o),
    .n_o    (n_o),
    .z_o    (z_o)
);

// File: tb/shf_unit_tb.sv
module shf_unit_tb;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        op_i = '0;
    logic              alt_i = 1'b0;
    logic [1:0]        wid_i = '0;
    logic [CNT_W-1:0]  cnt_i = '0;
    logic [DATA_W-1:0] opnd_i = '0;
    logic              c_i = 1'b0;
    logic [DATA_W-1:0] res_o;
    logic              c_o;
    logic              n_o;
    logic              z_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    shf_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .alt_i(alt_i), .wid_i(wid_i),
        .cnt_i(cnt_i), .opnd_i(opnd_i), .c_i(c_i), .res_o(res_o), .c_o(c_o),
        .n_o(n_o), .z_o(z_o)
    );

    function automatic string req_tag(input logic [1:0] op, input logic alt, input int cnt);
        if (cnt == 0) return "R3";
        case ({op, alt})
            3'b000:  return "R4";
            3'b001:  return "R5";
            3'b010:  return "R6";
            3'b011:  return "R7";
            3'b100, 3'b110: return "R8";
            default: return "R9";
        endcase
    endfunction

    // One bit per step, applied cnt times
    task automatic model(input logic [1:0] op, input logic alt, input int w,
                         input int cnt, input logic [31:0] din, input logic cin,
                         output logic [31:0] dout, output logic cout);
        logic [31:0] v;
        logic c, nc, top, low;
        v = din;
        c = cin;
        for (int s = 0; s < cnt; s++) begin
            top = v[w-1];
            low = v[0];
            case (op)
                2'd0: begin c = low; v = v >> 1; v[w-1] = alt ? top : 1'b0; end
                2'd1: begin c = top; v = v << 1; v[0] = alt ? low : 1'b0; end
                2'd2: begin nc = low; v = v >> 1; v[w-1] = alt ? low : c; c = nc; end
                default: begin nc = top; v = v << 1; v[0] = alt ? top : c; c = nc; end
            endcase
        end
        dout = (w == 32) ? v : ((din >> w) << w) | (v & ((32'd1 << w) - 1));
        cout = c;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        logic [31:0] exp_d;
        logic        exp_c;
        int          w;
        pats[0] = 32'h8000_8081;
        pats[1] = 32'h5A5A_A53C;
        pats[2] = 32'hFFFF_FFFE;
        pats[3] = 32'h1234_0080;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 res", res_o, 32'h0);
        check("R1 flags", {29'd0, c_o, n_o, z_o}, 32'h0);
        rst_n = 1'b1;

        for (int wd = 0; wd < 4; wd++) begin
            w = (wd == 0) ? 8 : (wd == 1) ? 16 : 32;
            for (int op = 0; op < 4; op++)
                for (int alt = 0; alt < 2; alt++)
                    for (int ci = 0; ci < 2; ci++)
                        for (int p = 0; p < 4; p++)
                            for (int k = 0; k < 2 * w + 4; k++) begin
                                int cnt;
                                cnt = (k == 2 * w + 3) ? 255 : k;
                                @(negedge clk);
                                op_i   = 2'(op);
                                alt_i  = alt[0];
                                wid_i  = 2'(wd);
                                cnt_i  = CNT_W'(cnt);
                                opnd_i = pats[p];
                                c_i    = ci[0];
                                model(2'(op), alt[0], w, cnt, pats[p], ci[0], exp_d, exp_c);
                                @(negedge clk);
                                // R1: result one edge after inputs
                                check(req_tag(2'(op), alt[0], cnt), {31'd0, c_o}, {31'd0, exp_c});
                                check(req_tag(2'(op), alt[0], cnt),
                                      res_o & ((w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1)),
                                      exp_d & ((w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1)));
                                if (w < 32)
                                    check("R2 upper", res_o >> w, pats[p] >> w);
                                check("R10 flags", {30'd0, n_o, z_o},
                                      {30'd0, exp_d[w-1],
                                       ((exp_d & ((w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1))) == 0)});
                            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule